// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion on one of eight analog channels. It selects the channel through a multiplexer select output. It holds an external sample-and-hold for a fixed sampling window. It then drives a trial code to an external DAC and reads back one comparator bit for each result bit, most significant first. The DAC, comparator and sample-and-hold are outside the block.

Software starts each conversion by writing a command that gives a channel and a start flag. When the flag is set, the conversion starts on the next clock. When it is clear, the command is held and waits for a pulse on a hardware trigger input. Every conversion uses up its command, so each one needs a new write. The finished result is shown as two bytes. The high byte carries the eight upper result bits. The low byte packs the two lowest bits, a busy flag and the channel number. A one-cycle done pulse marks the moment the result bytes change.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `res_hi`, `res_lo`, `dac_code`, `sample_hold` and `conv_done` are all zero.
- R2: A command write with `cmd_go`=1 while idle starts a conversion at that clock edge. From the next cycle, `res_lo[3]` (busy) is 1, `res_lo[2:0]` and `mux_sel` show the commanded channel, and `res_lo[5:4]` stay 0.
- R3: For the first 11 cycles of a conversion, `sample_hold` is 1 and `dac_code` is 0. After that, `sample_hold` is 0.
- R4: Busy stays 1 for exactly 91 cycles. In the cycle after the last one, busy is 0, the result bytes hold the new value and `conv_done` is 1 for that single cycle.
- R5: With an ideal comparator (`cmp_in` = input >= `dac_code`) and a 10-bit input V, `res_hi` = V[9:2] and `res_lo[7:6]` = V[1:0]. The result bytes stay unchanged between completions.
- R6: Each of the 10 bit intervals lasts 8 cycles, MSB first. In interval k (k=0 is the MSB), `dac_code` equals the bits already resolved, plus a 1 at bit 9-k.
- R7: A command write with `cmd_go`=0 while idle starts nothing. A later `hw_trig` pulse starts the conversion on the stored channel.
- R8: `hw_trig` with no stored command does nothing. A stored command is used up by one trigger, so a second trigger does nothing.
- R9: A command write during a conversion is ignored. It does not change the channel field, the length of the conversion, or any stored command.
- R10: While idle with a stored command, a new write replaces it. A new `cmd_go`=0 write changes the stored channel. A `cmd_go`=1 write starts at once and drops the stored command.
- R11: When `hw_trig` and a command write arrive in the same cycle while a command is stored, the trigger starts the stored command and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_chan | input | 3 | Channel number of the command |
| cmd_go | input | 1 | 1: start now, 0: wait for trigger |
| hw_trig | input | 1 | External start pulse for a stored command |
| cmp_in | input | 1 | Comparator: 1 when analog input >= DAC level |
| dac_code | output | 10 | Trial code for the external DAC |
| mux_sel | output | 3 | Analog multiplexer channel select |
| sample_hold | output | 1 | 1 while the input is being sampled |
| res_hi | output | 8 | Upper eight result bits |
| res_lo | output | 8 | {LSBs[1:0], 2'b00, busy, channel[2:0]} |
| conv_done | output | 1 | One-cycle pulse when the result updates |

## Verification
The assertions assume that `hw_trig` and `cmd_we` are synchronous single-cycle strobes. They also assume that `cmp_in` is settled at each clock edge. The bench meets both conditions. It models the comparator combinationally from the current `dac_code` and a 10-bit input value, and it changes that value only while idle. It also drives every strobe for exactly one cycle, from the falling edge. Random trials draw the channel, the input value and the start method, and directed cases cover the input extremes and collisions.

// File: rtl/sar_pkg.sv
// Shared constants for the conversion sequencer.
// Assumes one clock cycle per state time.
package sar_pkg;
    localparam int RES_BITS   = 10;
    localparam int CHAN_W     = 3;
    localparam int SAMPLE_CYC = 11;
    localparam int BIT_CYC    = 8;
    localparam int TOTAL_CYC  = 91;
endpackage

// File: rtl/sar_arm.sv
// Command capture: turns command writes and trigger pulses into a start strobe.
// Assumes cmd_we and hw_trig are single-cycle synchronous strobes.
module sar_arm #(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              cmd_go,
    input  logic              hw_trig,
    input  logic              busy,
    output logic              start,
    output logic [CHAN_W-1:0] start_chan
);
    logic              armed_q;
    logic [CHAN_W-1:0] armed_chan_q;
    logic              trig_start;
    logic              cmd_start;

    // Decide the start source; a trigger on a stored command wins over a write.
    always_comb begin
        trig_start = !busy && armed_q && hw_trig;
        cmd_start  = !busy && !trig_start && cmd_we && cmd_go;
        start      = trig_start || cmd_start;
        start_chan = trig_start ? armed_chan_q : cmd_chan;
    end

    // Hold a deferred command until a trigger uses it up or a new write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q      <= 1'b0;
            armed_chan_q <= '0;
        end else if (!busy) begin
            if (trig_start) begin
                armed_q <= 1'b0;
            end else if (cmd_we) begin
                armed_q      <= !cmd_go;
                armed_chan_q <= cmd_chan;
            end
        end
    end

    p_trig_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && armed_q && hw_trig) |=> !armed_q);
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> ($stable(armed_q) && $stable(armed_chan_q)));
endmodule

// File: rtl/sar_seq.sv
// Conversion timing and successive-approximation register.
// Assumes cmp_in is settled at each edge and that start only arrives while idle.
module sar_seq #(
    parameter int RES_BITS   = 10,
    parameter int SAMPLE_CYC = 11,
    parameter int BIT_CYC    = 8,
    parameter int TOTAL_CYC  = 91
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cmp_in,
    output logic                busy,
    output logic                sampling,
    output logic                finish,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result_val
);
    localparam int CW = $clog2(TOTAL_CYC);

    logic [CW-1:0]       cnt_q;
    logic                busy_q;
    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] code_nxt;

    // Phase decode for the outputs.
    always_comb begin
        busy     = busy_q;
        sampling = busy_q && (int'(cnt_q) < SAMPLE_CYC);
        finish   = busy_q && (int'(cnt_q) == TOTAL_CYC - 1);
        dac_code = code_q;
    end

    // Next trial code: set the MSB after sampling, then resolve one bit per interval.
    always_comb begin
        code_nxt = code_q;
        if (busy_q && int'(cnt_q) == SAMPLE_CYC - 1)
            code_nxt[RES_BITS-1] = 1'b1;
        for (int k = 0; k < RES_BITS; k++) begin
            if (busy_q && int'(cnt_q) == SAMPLE_CYC + (k + 1) * BIT_CYC - 1) begin
                if (!cmp_in)
                    code_nxt[RES_BITS-1-k] = 1'b0;
                if (k < RES_BITS - 1)
                    code_nxt[RES_BITS-2-k] = 1'b1;
            end
        end
        result_val = code_nxt;
    end

    // Cycle counter, busy flag and code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            code_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            code_q <= '0;
        end else if (busy_q) begin
            code_q <= code_nxt;
            if (finish) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt_q == '0));
    p_sample_dac_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> (dac_code == '0));
    p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);
    p_finish_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);
endmodule

// File: rtl/sar_result.sv
// Result bytes, channel field and done pulse.
// Assumes RES_BITS - 8 equals 2, so the low byte packs exactly as documented.
module sar_result #(
    parameter int RES_BITS = 10,
    parameter int CHAN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CHAN_W-1:0]   start_chan,
    input  logic                finish,
    input  logic                busy,
    input  logic [RES_BITS-1:0] result_val,
    output logic [7:0]          res_hi,
    output logic [7:0]          res_lo,
    output logic [CHAN_W-1:0]   chan,
    output logic                done
);
    localparam int LO_W  = RES_BITS - 8;
    localparam int PAD_W = 8 - LO_W - 1 - CHAN_W;

    logic [7:0]        hi_q;
    logic [LO_W-1:0]   lo_q;
    logic [CHAN_W-1:0] chan_q;
    logic              done_q;

    // Latch the channel at start and the result at finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            chan_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (start)
                chan_q <= start_chan;
            if (finish) begin
                hi_q <= result_val[RES_BITS-1:LO_W];
                lo_q <= result_val[LO_W-1:0];
            end
        end
    end

    // Pack the status byte.
    always_comb begin
        res_hi = hi_q;
        res_lo = {lo_q, {PAD_W{1'b0}}, busy, chan_q};
        chan   = chan_q;
        done   = done_q;
    end

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_result_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top level of the successive-approximation conversion sequencer.
// Assumes an external DAC, comparator and sample-and-hold; one state time per clock.
module sar_adc_ctrl
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_we,
    input  logic [CHAN_W-1:0]   cmd_chan,
    input  logic                cmd_go,
    input  logic                hw_trig,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CHAN_W-1:0]   mux_sel,
    output logic                sample_hold,
    output logic [7:0]          res_hi,
    output logic [7:0]          res_lo,
    output logic                conv_done
);
    logic                start;
    logic [CHAN_W-1:0]   start_chan;
    logic                busy;
    logic                finish;
    logic [RES_BITS-1:0] result_val;

    sar_arm #(.CHAN_W(CHAN_W)) u_arm (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_chan(cmd_chan),
        .cmd_go(cmd_go), .hw_trig(hw_trig), .busy(busy),
        .start(start), .start_chan(start_chan)
    );

    sar_seq #(
        .RES_BITS(RES_BITS), .SAMPLE_CYC(SAMPLE_CYC),
        .BIT_CYC(BIT_CYC), .TOTAL_CYC(TOTAL_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
        .busy(busy), .sampling(sample_hold), .finish(finish),
        .dac_code(dac_code), .result_val(result_val)
    );

    sar_result #(.RES_BITS(RES_BITS), .CHAN_W(CHAN_W)) u_res (
        .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan),
        .finish(finish), .busy(busy), .result_val(result_val),
        .res_hi(res_hi), .res_lo(res_lo), .chan(mux_sel), .done(conv_done)
    );
endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd_chan = '0;
    logic       cmd_go = 1'b0;
    logic       hw_trig = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;
    logic       sample_hold;
    logic [7:0] res_hi, res_lo;
    logic       conv_done;
    logic [9:0] vin = '0;
    int         n_run = 0, n_fail = 0;
    bit         ended = 1'b0;

    always #2.5 clk = ~clk;
    assign cmp_in = (vin >= dac_code);

    sar_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_chan(cmd_chan),
        .cmd_go(cmd_go), .hw_trig(hw_trig), .cmp_in(cmp_in),
        .dac_code(dac_code), .mux_sel(mux_sel), .sample_hold(sample_hold),
        .res_hi(res_hi), .res_lo(res_lo), .conv_done(conv_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected DAC trial code in conversion cycle cyc for input v (R3, R6).
    function automatic logic [9:0] exp_dac(input logic [9:0] v, input int cyc);
        int k;
        logic [9:0] mask;
        if (cyc < 11) return 10'd0;
        k = (cyc - 11) / 8;
        mask = 10'((((1 << k) - 1) << (10 - k)));
        return (v & mask) | 10'(1 << (9 - k));
    endfunction

    function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic bsy, input logic [2:0] ch);
        return {v[1:0], 2'b00, bsy, ch};
    endfunction

    task automatic write_cmd(input logic [2:0] ch, input logic go);
        @(negedge clk);
        cmd_we = 1'b1; cmd_chan = ch; cmd_go = go;
        @(negedge clk);
        cmd_we = 1'b0; cmd_go = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
    endtask

    // Called at the negedge of conversion cycle 0; follows all 91 cycles and the finish.
    task automatic follow_conv(input logic [2:0] ch, input logic [9:0] v, input bit inject);
        for (int cyc = 0; cyc < 91; cyc++) begin
            check("R4 busy bit", 32'(res_lo[3]), 32'd1);
            check("R2 channel field", 32'(res_lo[2:0]), 32'(ch));
            check("R2 mux_sel", 32'(mux_sel), 32'(ch));
            check("R2 pad bits", 32'(res_lo[5:4]), 32'd0);
            check("R3 sample_hold", 32'(sample_hold), 32'(cyc < 11));
            check("R6 dac_code", 32'(dac_code), 32'(exp_dac(v, cyc)));
            check("R4 done low while busy", 32'(conv_done), 32'd0);
            if (inject && (cyc == 20 || cyc == 40)) begin
                cmd_we = 1'b1; cmd_chan = ~ch; cmd_go = (cyc == 20);
            end else begin
                cmd_we = 1'b0; cmd_go = 1'b0;
            end
            @(negedge clk);
        end
        check("R4 busy cleared", 32'(res_lo[3]), 32'd0);
        check("R4 done pulse", 32'(conv_done), 32'd1);
        check("R5 res_hi", 32'(res_hi), 32'(v[9:2]));
        check("R5 res_lo", 32'(res_lo), 32'(exp_lo(v, 1'b0, ch)));
        @(negedge clk);
        check("R4 done one cycle", 32'(conv_done), 32'd0);
    endtask

    task automatic conv_go(input logic [2:0] ch, input logic [9:0] v, input bit inject);
        vin = v;
        @(negedge clk);
        cmd_we = 1'b1; cmd_chan = ch; cmd_go = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0; cmd_go = 1'b0;
        follow_conv(ch, v, inject);
    endtask

    task automatic conv_trig(input logic [2:0] ch, input logic [9:0] v);
        vin = v;
        write_cmd(ch, 1'b0);
        check("R7 no start on deferred write", 32'(res_lo[3]), 32'd0);
        pulse_trig();
        follow_conv(ch, v, 1'b0);
    endtask

    // Several idle cycles: nothing starts and the result bytes hold.
    task automatic idle_check(input string tag, input int n);
        logic [7:0] hi0, lo0;
        hi0 = res_hi; lo0 = res_lo;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, 32'(res_lo[3]), 32'd0);
            check(tag, 32'({res_hi, res_lo}), 32'({hi0, lo0}));
        end
    endtask

    initial begin
        #750000;
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_hi", 32'(res_hi), 32'd0);
        check("R1 res_lo", 32'(res_lo), 32'd0);
        check("R1 dac_code", 32'(dac_code), 32'd0);
        check("R1 sample_hold", 32'(sample_hold), 32'd0);
        check("R1 conv_done", 32'(conv_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: immediate starts at the input extremes
        conv_go(3'd5, 10'd0, 1'b0);
        conv_go(3'd0, 10'd1023, 1'b0);
        conv_go(3'd7, 10'd512, 1'b0);
        conv_go(3'd2, 10'd511, 1'b0);

        // R8: a trigger with nothing stored
        pulse_trig();
        idle_check("R8 stray trigger", 4);

        // R7 then R8: deferred start, then a second trigger does nothing
        conv_trig(3'd2, 10'd300);
        pulse_trig();
        idle_check("R8 command used up", 4);

        // R10: a deferred write replaces the stored channel
        vin = 10'd777;
        write_cmd(3'd1, 1'b0);
        write_cmd(3'd6, 1'b0);
        pulse_trig();
        follow_conv(3'd6, 10'd777, 1'b0);
        // R10: an immediate write drops the stored command
        write_cmd(3'd3, 1'b0);
        conv_go(3'd4, 10'd85, 1'b0);
        pulse_trig();
        idle_check("R10 stored command dropped", 4);

        // R9: writes during a conversion are ignored
        conv_go(3'd1, 10'd640, 1'b1);
        pulse_trig();
        idle_check("R9 busy write not stored", 4);

        // R11: trigger and write in the same cycle
        vin = 10'd222;
        write_cmd(3'd3, 1'b0);
        @(negedge clk);
        hw_trig = 1'b1; cmd_we = 1'b1; cmd_chan = 3'd0; cmd_go = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0; cmd_we = 1'b0; cmd_go = 1'b0;
        follow_conv(3'd3, 10'd222, 1'b0);
        idle_check("R11 colliding write dropped", 3);

        // Random trials: R5 R6 R7 with random channel, input and start method
        for (int t = 0; t < 24; t++) begin
            logic [2:0] ch;
            logic [9:0] v;
            ch = 3'($urandom_range(0, 7));
            v  = 10'($urandom_range(0, 1023));
            if ($urandom_range(0, 1) == 1) conv_go(ch, v, 1'b0);
            else conv_trig(ch, v);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule